// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter

This block lets a fixed number of bus initiators share one target over a Wishbone-style single-target bus. One initiator holds a grant at a time. The grant is kept in a register and passed on in round-robin order. The holder's request fields are multiplexed onto the shared target bus. The target's responses are returned only to the holder. Every other initiator sees a quiet response and a held-off stall.

Initiators do not all need the same interface. An initiator may address byte lanes in units coarser than the shared bus; its select bits are widened lane by lane. An initiator may have no lock wire, or no cycle-type and burst-type wires; the block supplies values for them. The target may also have no stall wire, in which case stall is derived from its acknowledge. All of these differences are compile-time parameters. Request and response routing is combinational, so an acknowledge reaches the holder in the same cycle the target raises it.

Top module: `rr_bus_arbiter`

## Requirements
- R1: While reset is asserted, the grant register loads initiator 0. Right after reset, raising target ack with no initiator active acknowledges port 0 only.
- R2: At a rising edge where the holder may release, the grant moves to the first initiator with cyc high, searching upward from the holder and wrapping. If only the holder requests, it keeps the grant. Requests {0,2},{2},{0,1},{1,2},{0,2} on successive edges, starting from reset, give grants 0,2,0,1,2.
- R3: The holder keeps the grant while its cyc is high and either its effective lock or its stb is high. It may release only when cyc is low, or when both lock and stb are low.
- R4: The shared bus cyc, stb, we, address and write data equal the holder's fields in the same cycle.
- R5: Target read data, ack, err and rty reach the holder in the same cycle. Every other port sees ack, err and rty at 0 and read data at 0.
- R6: Each port carries a 2-bit parameter field k, the log2 of how much coarser its granularity is than the bus. Bus select bit i equals the port's select bit i>>k. For k=1 a select of 0b10 drives 0b1100.
- R7: For a port built without a lock wire, the shared lock output and the arbitration use that port's cyc as its lock.
- R8: For a port built without cycle-type and burst-type wires, the shared bus drives cycle type 3'b000 (classic) and burst type 2'b00 (linear). Otherwise the holder's values pass through.
- R9: Ports that do not hold the grant always see stall at 1. The holder sees the target's stall when the target has a stall wire.
- R10: When the target is built without a stall wire, the holder sees stall equal to the inverse of the target's ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | NUM_PORTS | Per-initiator bus cycle active |
| m_stb | input | NUM_PORTS | Per-initiator strobe |
| m_we | input | NUM_PORTS | Per-initiator write enable |
| m_lock | input | NUM_PORTS | Per-initiator lock (ignored for ports without lock) |
| m_adr | input | NUM_PORTS*ADDR_W | Per-initiator address, port i at slice i |
| m_dat_w | input | NUM_PORTS*DATA_W | Per-initiator write data |
| m_sel | input | NUM_PORTS*SEL_W | Per-initiator byte-lane select at its own granularity |
| m_cti | input | NUM_PORTS*3 | Per-initiator cycle type |
| m_bte | input | NUM_PORTS*2 | Per-initiator burst type |
| m_dat_r | output | NUM_PORTS*DATA_W | Per-initiator read data |
| m_ack | output | NUM_PORTS | Per-initiator acknowledge |
| m_err | output | NUM_PORTS | Per-initiator error |
| m_rty | output | NUM_PORTS | Per-initiator retry |
| m_stall | output | NUM_PORTS | Per-initiator stall |
| s_cyc | output | 1 | Shared bus cycle active |
| s_stb | output | 1 | Shared bus strobe |
| s_we | output | 1 | Shared bus write enable |
| s_lock | output | 1 | Shared bus lock |
| s_adr | output | ADDR_W | Shared bus address |
| s_dat_w | output | DATA_W | Shared bus write data |
| s_sel | output | SEL_W | Shared bus lane select at bus granularity |
| s_cti | output | 3 | Shared bus cycle type |
| s_bte | output | 2 | Shared bus burst type |
| s_dat_r | input | DATA_W | Target read data |
| s_ack | input | 1 | Target acknowledge |
| s_err | input | 1 | Target error |
| s_rty | input | 1 | Target retry |
| s_stall | input | 1 | Target stall (ignored when the target has none) |

## Verification
The only state in the block is the grant register. If it is wrong, the shared bus immediately carries another initiator's address, data and select. In the same cycle, the ack, err, rty, stall and read data appear on the wrong port. A wrong release decision shows one edge later: the grant moves during a locked or strobed transfer, or stays stuck after the holder has dropped cyc. The bench keeps its own model of the grant and compares every routed field on every cycle, so a wrong grant shows within one clock of its cause.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;

  typedef enum logic [2:0] {
    CT_CLASSIC = 3'b000,
    CT_CONST   = 3'b001,
    CT_INCR    = 3'b010,
    CT_LAST    = 3'b111
  } cycle_kind_e;

  typedef enum logic [1:0] {
    BT_LINEAR = 2'b00,
    BT_WRAP4  = 2'b01,
    BT_WRAP8  = 2'b10,
    BT_WRAP16 = 2'b11
  } burst_kind_e;

  localparam int CTI_W = 3;
  localparam int BTE_W = 2;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rrarb_port_adapt.sv
module rrarb_port_adapt
  import rrarb_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int RATIO_LOG2 = 0,
  parameter bit HAS_LOCK   = 1'b1,
  parameter bit HAS_BURST  = 1'b1
) (
  input  logic             cyc_i,
  input  logic             lock_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CTI_W-1:0] cti_i,
  input  logic [BTE_W-1:0] bte_i,
  output logic             lock_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [CTI_W-1:0] cti_o,
  output logic [BTE_W-1:0] bte_o
);

  // Lane widening: each coarse select bit covers 2**RATIO_LOG2 fine lanes.
  for (genvar i = 0; i < SEL_W; i++) begin : g_lane
    assign sel_o[i] = sel_i[i >> RATIO_LOG2];
  end

  if (HAS_LOCK) begin : g_lock
    assign lock_o = lock_i;
  end else begin : g_nolock
    assign lock_o = cyc_i;
  end

  if (HAS_BURST) begin : g_burst
    assign cti_o = cti_i;
    assign bte_o = bte_i;
  end else begin : g_noburst
    assign cti_o = CT_CLASSIC;
    assign bte_o = BT_LINEAR;
  end

  logic unused_port_in;
  assign unused_port_in = ^{lock_i, sel_i, cti_i, bte_i};

endmodule

// File: rtl/rrarb_grant.sv
module rrarb_grant #(
  parameter int NUM_PORTS = 3,
  parameter int IW        = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] cyc,
  input  logic [NUM_PORTS-1:0] stb,
  input  logic [NUM_PORTS-1:0] lock_eff,
  output logic [IW-1:0]        grant_q
);

  logic          may_release;
  logic [IW-1:0] grant_d;

  assign may_release = !cyc[grant_q] || (!lock_eff[grant_q] && !stb[grant_q]);

  // Search upward from the holder; the holder itself is tried last.
  always_comb begin
    int  idx;
    logic found;
    grant_d = grant_q;
    found   = 1'b0;
    idx     = 0;
    if (may_release) begin
      for (int k = 1; k <= NUM_PORTS; k++) begin
        idx = (int'(grant_q) + k) % NUM_PORTS;
        if (!found && cyc[idx]) begin
          grant_d = IW'(idx);
          found   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) grant_q <= '0;
    else     grant_q <= grant_d;
  end

endmodule

// File: rtl/rrarb_resp_route.sv
module rrarb_resp_route #(
  parameter int NUM_PORTS     = 3,
  parameter int IW            = 2,
  parameter int DATA_W        = 32,
  parameter bit TGT_HAS_STALL = 1'b1
) (
  input  logic [IW-1:0]               grant,
  input  logic [DATA_W-1:0]           s_dat_r,
  input  logic                        s_ack,
  input  logic                        s_err,
  input  logic                        s_rty,
  input  logic                        s_stall,
  output logic [NUM_PORTS*DATA_W-1:0] m_dat_r,
  output logic [NUM_PORTS-1:0]        m_ack,
  output logic [NUM_PORTS-1:0]        m_err,
  output logic [NUM_PORTS-1:0]        m_rty,
  output logic [NUM_PORTS-1:0]        m_stall
);

  logic holder_stall;

  if (TGT_HAS_STALL) begin : g_tstall
    assign holder_stall = s_stall;
  end else begin : g_ackstall
    assign holder_stall = ~s_ack;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic mine;
    assign mine                        = (grant == IW'(i));
    assign m_ack[i]                    = mine & s_ack;
    assign m_err[i]                    = mine & s_err;
    assign m_rty[i]                    = mine & s_rty;
    assign m_stall[i]                  = mine ? holder_stall : 1'b1;
    assign m_dat_r[i*DATA_W +: DATA_W] = mine ? s_dat_r : '0;
  end

  logic unused_route_in;
  assign unused_route_in = s_stall;

endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter
  import rrarb_pkg::*;
#(
  parameter int                     NUM_PORTS       = 3,
  parameter int                     ADDR_W          = 30,
  parameter int                     DATA_W          = 32,
  parameter int                     BUS_GRAN        = 8,
  parameter logic [NUM_PORTS*2-1:0] PORT_RATIO_LOG2 = '0,
  parameter logic [NUM_PORTS-1:0]   PORT_HAS_LOCK   = '1,
  parameter logic [NUM_PORTS-1:0]   PORT_HAS_BURST  = '1,
  parameter bit                     TGT_HAS_STALL   = 1'b1,
  localparam int                    SEL_W           = DATA_W / BUS_GRAN,
  localparam int                    IW              = idx_bits(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        m_cyc,
  input  logic [NUM_PORTS-1:0]        m_stb,
  input  logic [NUM_PORTS-1:0]        m_we,
  input  logic [NUM_PORTS-1:0]        m_lock,
  input  logic [NUM_PORTS*ADDR_W-1:0] m_adr,
  input  logic [NUM_PORTS*DATA_W-1:0] m_dat_w,
  input  logic [NUM_PORTS*SEL_W-1:0]  m_sel,
  input  logic [NUM_PORTS*3-1:0]      m_cti,
  input  logic [NUM_PORTS*2-1:0]      m_bte,
  output logic [NUM_PORTS*DATA_W-1:0] m_dat_r,
  output logic [NUM_PORTS-1:0]        m_ack,
  output logic [NUM_PORTS-1:0]        m_err,
  output logic [NUM_PORTS-1:0]        m_rty,
  output logic [NUM_PORTS-1:0]        m_stall,
  output logic                        s_cyc,
  output logic                        s_stb,
  output logic                        s_we,
  output logic                        s_lock,
  output logic [ADDR_W-1:0]           s_adr,
  output logic [DATA_W-1:0]           s_dat_w,
  output logic [SEL_W-1:0]            s_sel,
  output logic [2:0]                  s_cti,
  output logic [1:0]                  s_bte,
  input  logic [DATA_W-1:0]           s_dat_r,
  input  logic                        s_ack,
  input  logic                        s_err,
  input  logic                        s_rty,
  input  logic                        s_stall
);

  logic [NUM_PORTS*SEL_W-1:0] sel_n;
  logic [NUM_PORTS-1:0]       lock_n;
  logic [NUM_PORTS*3-1:0]     cti_n;
  logic [NUM_PORTS*2-1:0]     bte_n;
  logic [IW-1:0]              grant_q;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_adapt
    rrarb_port_adapt #(
      .SEL_W      (SEL_W),
      .RATIO_LOG2 (int'(PORT_RATIO_LOG2[i*2 +: 2])),
      .HAS_LOCK   (PORT_HAS_LOCK[i]),
      .HAS_BURST  (PORT_HAS_BURST[i])
    ) u_adapt (
      .cyc_i  (m_cyc[i]),
      .lock_i (m_lock[i]),
      .sel_i  (m_sel[i*SEL_W +: SEL_W]),
      .cti_i  (m_cti[i*3 +: 3]),
      .bte_i  (m_bte[i*2 +: 2]),
      .lock_o (lock_n[i]),
      .sel_o  (sel_n[i*SEL_W +: SEL_W]),
      .cti_o  (cti_n[i*3 +: 3]),
      .bte_o  (bte_n[i*2 +: 2])
    );
  end

  rrarb_grant #(
    .NUM_PORTS (NUM_PORTS),
    .IW        (IW)
  ) u_grant (
    .clk      (clk),
    .rst      (rst),
    .cyc      (m_cyc),
    .stb      (m_stb),
    .lock_eff (lock_n),
    .grant_q  (grant_q)
  );

  // Request path: plain multiplexer on the registered grant.
  int gi;
  always_comb begin
    gi      = int'(grant_q);
    s_cyc   = m_cyc[grant_q];
    s_stb   = m_stb[grant_q];
    s_we    = m_we[grant_q];
    s_lock  = lock_n[grant_q];
    s_adr   = m_adr[gi*ADDR_W +: ADDR_W];
    s_dat_w = m_dat_w[gi*DATA_W +: DATA_W];
    s_sel   = sel_n[gi*SEL_W +: SEL_W];
    s_cti   = cti_n[gi*3 +: 3];
    s_bte   = bte_n[gi*2 +: 2];
  end

  rrarb_resp_route #(
    .NUM_PORTS     (NUM_PORTS),
    .IW            (IW),
    .DATA_W        (DATA_W),
    .TGT_HAS_STALL (TGT_HAS_STALL)
  ) u_route (
    .grant   (grant_q),
    .s_dat_r (s_dat_r),
    .s_ack   (s_ack),
    .s_err   (s_err),
    .s_rty   (s_rty),
    .s_stall (s_stall),
    .m_dat_r (m_dat_r),
    .m_ack   (m_ack),
    .m_err   (m_err),
    .m_rty   (m_rty),
    .m_stall (m_stall)
  );

endmodule

// File: rtl/rrarb_checker.sv
module rrarb_checker #(
  parameter int NUM_PORTS = 3,
  parameter int IW        = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [IW-1:0]        grant,
  input logic [NUM_PORTS-1:0] m_cyc,
  input logic [NUM_PORTS-1:0] m_ack,
  input logic [NUM_PORTS-1:0] m_err,
  input logic [NUM_PORTS-1:0] m_rty,
  input logic [NUM_PORTS-1:0] m_stall,
  input logic                 s_cyc,
  input logic                 s_stb,
  input logic                 s_lock,
  input logic                 s_ack
);

  logic [NUM_PORTS-1:0] prev_cyc;
  always_ff @(posedge clk) begin
    if (rst) prev_cyc <= '0;
    else     prev_cyc <= m_cyc;
  end

  p_reset_grant_r1: assert property (@(posedge clk) rst |=> (grant == '0));

  p_move_to_requester_r2: assert property (@(posedge clk) disable iff (rst)
    (grant != $past(grant)) |-> prev_cyc[grant]);

  p_hold_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (s_cyc && (s_lock || s_stb)) |=> $stable(grant));

  p_single_response_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_ack) && $onehot0(m_err) && $onehot0(m_rty));

  p_ack_delivered_r5: assert property (@(posedge clk) disable iff (rst)
    s_ack |-> ($countones(m_ack) == 1));

  p_quiet_without_ack_r5: assert property (@(posedge clk) disable iff (rst)
    !s_ack |-> (m_ack == '0));

  p_others_stalled_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(m_stall) >= NUM_PORTS - 1);

endmodule

bind rr_bus_arbiter rrarb_checker #(
  .NUM_PORTS (NUM_PORTS),
  .IW        (IW)
) u_rrarb_checker (
  .clk     (clk),
  .rst     (rst),
  .grant   (grant_q),
  .m_cyc   (m_cyc),
  .m_ack   (m_ack),
  .m_err   (m_err),
  .m_rty   (m_rty),
  .m_stall (m_stall),
  .s_cyc   (s_cyc),
  .s_stb   (s_stb),
  .s_lock  (s_lock),
  .s_ack   (s_ack)
);

// File: tb/test_rr_bus_arbiter.sv
`timescale 1ns/1ps
module test_rr_bus_arbiter;

  localparam int NP = 3;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam logic [NP*2-1:0] RATIO  = 6'b00_01_00;
  localparam logic [NP-1:0]   HLOCK  = 3'b101;
  localparam logic [NP-1:0]   HBURST = 3'b011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NP-1:0]    m_cyc = '0, m_stb = '0, m_we = '0, m_lock = '0;
  logic [NP*AW-1:0] m_adr = '0;
  logic [NP*DW-1:0] m_dat_w = '0;
  logic [NP*SW-1:0] m_sel = '0;
  logic [NP*3-1:0]  m_cti = '0;
  logic [NP*2-1:0]  m_bte = '0;
  logic [DW-1:0]    s_dat_r = '0;
  logic             s_ack = 1'b0, s_err = 1'b0, s_rty = 1'b0, s_stall = 1'b0;

  logic [NP*DW-1:0] m_dat_r, n_dat_r;
  logic [NP-1:0]    m_ack, m_err, m_rty, m_stall, n_ack, n_err, n_rty, n_stall;
  logic             s_cyc, s_stb, s_we, s_lock, n_cyc, n_stb, n_we, n_lock;
  logic [AW-1:0]    s_adr, n_adr;
  logic [DW-1:0]    s_dat_w, n_dat_w;
  logic [SW-1:0]    s_sel, n_sel;
  logic [2:0]       s_cti, n_cti;
  logic [1:0]       s_bte, n_bte;

  rr_bus_arbiter #(
    .NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .BUS_GRAN(8),
    .PORT_RATIO_LOG2(RATIO), .PORT_HAS_LOCK(HLOCK), .PORT_HAS_BURST(HBURST),
    .TGT_HAS_STALL(1'b1)
  ) i_rr_bus_arbiter (
    .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_lock(m_lock),
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_cti(m_cti), .m_bte(m_bte),
    .m_dat_r(m_dat_r), .m_ack(m_ack), .m_err(m_err), .m_rty(m_rty), .m_stall(m_stall),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_lock(s_lock), .s_adr(s_adr),
    .s_dat_w(s_dat_w), .s_sel(s_sel), .s_cti(s_cti), .s_bte(s_bte),
    .s_dat_r(s_dat_r), .s_ack(s_ack), .s_err(s_err), .s_rty(s_rty), .s_stall(s_stall)
  );

  rr_bus_arbiter #(
    .NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .BUS_GRAN(8),
    .PORT_RATIO_LOG2(RATIO), .PORT_HAS_LOCK(HLOCK), .PORT_HAS_BURST(HBURST),
    .TGT_HAS_STALL(1'b0)
  ) i_rr_bus_arbiter_nostall (
    .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_lock(m_lock),
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_cti(m_cti), .m_bte(m_bte),
    .m_dat_r(n_dat_r), .m_ack(n_ack), .m_err(n_err), .m_rty(n_rty), .m_stall(n_stall),
    .s_cyc(n_cyc), .s_stb(n_stb), .s_we(n_we), .s_lock(n_lock), .s_adr(n_adr),
    .s_dat_w(n_dat_w), .s_sel(n_sel), .s_cti(n_cti), .s_bte(n_bte),
    .s_dat_r(s_dat_r), .s_ack(s_ack), .s_err(s_err), .s_rty(s_rty), .s_stall(s_stall)
  );

  int nchk  = 0;
  int nfail = 0;
  int g     = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int next_g(input int cur, input logic [NP-1:0] c,
                                input logic [NP-1:0] s, input logic [NP-1:0] l);
    logic [NP-1:0] le;
    for (int i = 0; i < NP; i++) le[i] = HLOCK[i] ? l[i] : c[i];
    if (c[cur] && (le[cur] || s[cur])) return cur;
    for (int k = 1; k <= NP; k++) begin
      if (c[(cur + k) % NP]) return (cur + k) % NP;
    end
    return cur;
  endfunction

  function automatic logic [SW-1:0] exp_sel(input int p, input logic [NP*SW-1:0] sv);
    logic [SW-1:0] raw, o;
    int r;
    raw = sv[p*SW +: SW];
    r   = int'(RATIO[p*2 +: 2]);
    for (int i = 0; i < SW; i++) o[i] = raw[i >> r];
    return o;
  endfunction

  // Advance one clock, updating the bench's grant model from the inputs at the edge.
  task automatic tick();
    int nx;
    nx = next_g(g, m_cyc, m_stb, m_lock);
    @(posedge clk);
    g = nx;
    #2;
  endtask

  task automatic check_all();
    chk("R4 cyc", 64'(s_cyc), 64'(m_cyc[g]));
    chk("R4 stb", 64'(s_stb), 64'(m_stb[g]));
    chk("R4 we", 64'(s_we), 64'(m_we[g]));
    chk("R4 adr", 64'(s_adr), 64'(m_adr[g*AW +: AW]));
    chk("R4 dat_w", 64'(s_dat_w), 64'(m_dat_w[g*DW +: DW]));
    chk("R6 sel", 64'(s_sel), 64'(exp_sel(g, m_sel)));
    chk("R7 lock", 64'(s_lock), 64'(HLOCK[g] ? m_lock[g] : m_cyc[g]));
    chk("R8 cti", 64'(s_cti), HBURST[g] ? 64'(m_cti[g*3 +: 3]) : 64'(0));
    chk("R8 bte", 64'(s_bte), HBURST[g] ? 64'(m_bte[g*2 +: 2]) : 64'(0));
    for (int i = 0; i < NP; i++) begin
      chk("R5 ack", 64'(m_ack[i]), 64'((i == g) && s_ack));
      chk("R5 err", 64'(m_err[i]), 64'((i == g) && s_err));
      chk("R5 rty", 64'(m_rty[i]), 64'((i == g) && s_rty));
      chk("R5 dat_r", 64'(m_dat_r[i*DW +: DW]), (i == g) ? 64'(s_dat_r) : 64'(0));
      chk("R9 stall", 64'(m_stall[i]), (i == g) ? 64'(s_stall) : 64'(1));
      chk("R10 stall", 64'(n_stall[i]), (i == g) ? 64'(!s_ack) : 64'(1));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    g   = 0;

    // R1: reset grant is port 0
    s_ack = 1'b1;
    #2;
    chk("R1 ack after reset", 64'(m_ack), 64'(3'b001));
    chk("R9 idle stall", 64'(m_stall), 64'(3'b110));

    // R2: round-robin sequence
    m_cyc = 3'b101; #2;
    chk("R2 step0", 64'(m_ack), 64'(3'b001));
    m_cyc = 3'b100; tick();
    chk("R2 step1", 64'(m_ack), 64'(3'b100));
    m_cyc = 3'b011; tick();
    chk("R2 step2", 64'(m_ack), 64'(3'b001));
    m_cyc = 3'b110; tick();
    chk("R2 step3", 64'(m_ack), 64'(3'b010));
    m_cyc = 3'b101; tick();
    chk("R2 step4", 64'(m_ack), 64'(3'b100));

    // R3: lock and stb hold (ports 0 and 2); move port 2 -> 0 first
    m_cyc = 3'b001; tick();
    chk("R3 setup", 64'(m_ack), 64'(3'b001));
    m_cyc = 3'b101; m_lock = 3'b001; tick();
    chk("R3 lock hold", 64'(m_ack), 64'(3'b001));
    tick();
    chk("R3 lock hold again", 64'(m_ack), 64'(3'b001));
    m_lock = 3'b000; tick();
    chk("R3 release", 64'(m_ack), 64'(3'b100));
    m_cyc = 3'b001; tick();
    chk("R3 cyc drop", 64'(m_ack), 64'(3'b001));
    m_stb = 3'b001; m_cyc = 3'b101; tick();
    chk("R3 stb hold", 64'(m_ack), 64'(3'b001));
    m_stb = 3'b000; tick();
    chk("R3 stb release", 64'(m_ack), 64'(3'b100));

    // R6/R7: port 1 coarse select, no lock wire
    m_cyc = 3'b010; tick(); tick();
    m_sel = '0; m_sel[SW +: SW] = 4'b0010; #1;
    chk("R6 sel 0b10 widens", 64'(s_sel), 64'(4'b1100));
    chk("R7 lock from cyc", 64'(s_lock), 64'(1));

    // R8/R10: port 2 lacks burst wires
    m_cyc = 3'b100; m_cti = 9'b010_010_010; m_bte = 6'b01_01_01; tick();
    chk("R8 cti default", 64'(s_cti), 64'(0));
    chk("R8 bte default", 64'(s_bte), 64'(0));
    s_ack = 1'b0; #1;
    chk("R10 stall no ack", 64'(n_stall), 64'(3'b111));
    s_ack = 1'b1; #1;
    chk("R10 stall ack", 64'(n_stall), 64'(3'b011));

    // Random phase
    for (int n = 0; n < 400; n++) begin
      logic [2:0] c;
      c = 3'($urandom);
      if (($urandom % 4) == 0) c = '0;
      m_cyc  = c;
      m_stb  = 3'($urandom);
      m_we   = 3'($urandom);
      m_lock = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
      for (int i = 0; i < NP; i++) begin
        m_adr[i*AW +: AW]   = AW'($urandom);
        m_dat_w[i*DW +: DW] = $urandom;
      end
      m_sel   = 12'($urandom);
      m_cti   = 9'($urandom);
      m_bte   = 6'($urandom);
      s_dat_r = $urandom;
      s_ack   = 1'($urandom);
      s_err   = 1'($urandom);
      s_rty   = 1'($urandom);
      s_stall = 1'($urandom);
      #1;
      check_all();
      tick();
    end
    finish_run();
  end

endmodule